// File: doc/BRIEF.md
# Two-Key Register Write Lock

This unit guards a partition of a clock-configuration register bank against stray writes. It watches a simple register bus for writes to two 32-bit key registers. The partition opens only after the first key register receives its expected value and then the second key register receives its own. While the partition is locked, the unit holds back the write strobe that would reach the protected registers. Once it is unlocked, writes that fall inside the protected address window pass through.

Bit 0 of the first key register is a read-only flag that shows the unlock state. The other 31 bits of that register, and all 32 bits of the second key register, hold whatever software last wrote and read back as written. A wrong key, or a second key written without a correct first key before it, drops any progress and locks the partition. Once the partition is unlocked, writing anything but the correct first key locks it again.

Top module: `cfg_write_lock`

## Requirements
- R1: After reset, both key registers read 0, the unlock flag is 0, and the sequence holds no progress.
- R2: A read of the first key register (offset KEYA_OFS, default 0x10) returns the last written bits 31:1 with bit 0 replaced by the unlock flag (1 = unlocked). Bit 0 of the written data is not stored.
- R3: A read of the second key register (offset KEYA_OFS+4) returns all 32 bits last written.
- R4: A write of KEY_A to the first key register, followed later by a write of KEY_B to the second key register, sets the unlock flag. The `unlocked` output rises on the clock edge that accepts the second write.
- R5: A write of KEY_B to the second key register that does not follow a correct first-key write leaves the partition locked, even when the correct first key is written afterwards.
- R6: A wrong value written to the second key register after a correct first key clears the progress. A later correct second key then does not unlock.
- R7: Bit 0 of written data is ignored when the first key is compared.
- R8: While unlocked, a write to the first key register whose bits 31:1 differ from KEY_A, or any wrong write to the second key register, locks the partition on that edge.
- R9: `prot_wr_en` is high in the same cycle as a bus write exactly when the address lies in the inclusive range PROT_LO..PROT_HI (default 0x20..0x9C) and the partition is unlocked.
- R10: Writes to addresses other than the two key registers neither clear sequence progress nor change the unlock state.
- R11: Reads of any address other than the two key registers return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one beat per cycle |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| prot_wr_en | output | 1 | Write strobe passed to the protected partition |
| unlocked | output | 1 | Unlock state, the same as bit 0 of the first key register |

## Verification
The hardest case to reach is held progress: the first key is correct and the second has not arrived yet. Only an exact write order reaches it, and the only thing that shows it from outside is the effect of the next key write. The stimulus arms the sequence, then spends cycles on writes to other addresses, on a wrong second key, or on a reversed order, before it sends the correct second key. The unlock flag then shows whether the progress survived. The address window is swept over every word address both while locked and while unlocked, so both inclusive edges and the key offsets next to them are covered.

// File: rtl/cfg_write_lock.sv
module cfg_write_lock #(
  parameter int          ADDR_W   = 8,
  parameter logic [31:0] KEY_A    = 32'h68EF_3490,
  parameter logic [31:0] KEY_B    = 32'hD172_BC5A,
  parameter int          KEYA_OFS = 'h10,
  parameter int          PROT_LO  = 'h20,
  parameter int          PROT_HI  = 'h9C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              prot_wr_en,
  output logic              unlocked
);
  localparam int KEYB_OFS = KEYA_OFS + 4;

  logic [31:1] keya_q;
  logic [31:0] keyb_q;
  logic        armed_q, unl_q;

  wire hit_a  = (int'(bus_addr) == KEYA_OFS);
  wire hit_b  = (int'(bus_addr) == KEYB_OFS);
  wire wr_a   = bus_wr && hit_a;
  wire wr_b   = bus_wr && hit_b;
  wire good_a = (bus_wdata[31:1] == KEY_A[31:1]);
  wire good_b = (bus_wdata == KEY_B);
  wire in_win = (int'(bus_addr) >= PROT_LO) && (int'(bus_addr) <= PROT_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keya_q  <= '0;
      keyb_q  <= '0;
      armed_q <= 1'b0;
      unl_q   <= 1'b0;
    end else if (wr_a) begin
      keya_q  <= bus_wdata[31:1];
      armed_q <= good_a;
      if (!good_a) unl_q <= 1'b0;
    end else if (wr_b) begin
      keyb_q  <= bus_wdata;
      armed_q <= 1'b0;
      unl_q   <= (armed_q && good_b) ? 1'b1 : 1'b0;
    end
  end

  assign unlocked   = unl_q;
  assign prot_wr_en = bus_wr && in_win && unl_q;

  always_comb begin
    bus_rdata = '0;
    if (hit_a)      bus_rdata = {keya_q, unl_q};
    else if (hit_b) bus_rdata = keyb_q;
  end

  // R4
  unlock_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(bus_wr && int'(bus_addr) == KEYB_OFS && bus_wdata == KEY_B));

  // R5
  no_arm_no_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b && !armed_q) |=> !unlocked);

  // R8
  relock_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a && (bus_wdata[31:1] != KEY_A[31:1])) |=> !unlocked);

  // R9
  prot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_wr_en |-> (unlocked && bus_wr));

  // R2
  status_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_a |-> (bus_rdata[0] == unlocked));

  // R10
  other_wr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit_a && !hit_b) |=> $stable(unlocked));
endmodule

// File: tb/test_cfg_write_lock.sv
module test_cfg_write_lock;
  localparam int          AW   = 8;
  localparam logic [31:0] KA   = 32'h68EF_3490;
  localparam logic [31:0] KB   = 32'hD172_BC5A;
  localparam int          OA   = 'h10;
  localparam int          OB   = 'h14;
  localparam int          PLO  = 'h20;
  localparam int          PHI  = 'h9C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic prot_wr_en, unlocked;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  cfg_write_lock #(.ADDR_W(AW), .KEY_A(KA), .KEY_B(KB), .KEYA_OFS(OA),
                   .PROT_LO(PLO), .PROT_HI(PHI)) i_cfg_write_lock (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .prot_wr_en(prot_wr_en), .unlocked(unlocked));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, output logic prot);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a[AW-1:0]; bus_wdata = d;
    #1 prot = prot_wr_en;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a[AW-1:0];
    #1 d = bus_rdata;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(OA, d); chk("R1 keyA", d, 0);
    rd(OB, d); chk("R1 keyB", d, 0);
    chk("R1 unlocked", {31'b0, unlocked}, 0);
    // R11 unmapped read
    rd('h08, d); chk("R11 unmapped", d, 0);

    // R9 sweep while locked
    for (int a = 0; a < (1 << AW); a += 4) begin
      if (a == OA || a == OB) continue;
      wr(a, 32'hA5A5_0000 + a, p);
      chk("R9 locked sweep", {31'b0, p}, 0);
    end

    // R2 / R3 readback
    wr(OA, 32'hFFFF_FFFF, p);
    rd(OA, d); chk("R2 keyA readback", d, 32'hFFFF_FFFE);
    wr(OB, 32'h1234_5678, p);
    rd(OB, d); chk("R3 keyB readback", d, 32'h1234_5678);

    // R5 reversed order
    wr(OB, KB, p);
    wr(OA, KA, p);
    chk("R5 reversed", {31'b0, unlocked}, 0);
    // R6 wrong second key clears progress
    wr(OB, KB ^ 32'h1, p);
    chk("R6 wrong keyB", {31'b0, unlocked}, 0);
    wr(OB, KB, p);
    chk("R6 progress cleared", {31'b0, unlocked}, 0);

    // R7 + R4 correct sequence, bit 0 of key A flipped
    wr(OA, KA ^ 32'h1, p);
    chk("R4 not yet", {31'b0, unlocked}, 0);
    wr(OB, KB, p);
    chk("R4 unlocked", {31'b0, unlocked}, 1);
    rd(OA, d); chk("R2 status bit", d, {KA[31:1], 1'b1});

    // R9 sweep while unlocked (R10 keeps it open)
    for (int a = 0; a < (1 << AW); a += 4) begin
      if (a == OA || a == OB) continue;
      wr(a, 32'h5A5A_0000 + a, p);
      chk("R9 unlocked sweep", {31'b0, p}, {31'b0, (a >= PLO && a <= PHI)});
    end
    chk("R10 still unlocked", {31'b0, unlocked}, 1);

    // R8 wrong key A relocks
    wr(OA, KA ^ 32'h100, p);
    chk("R8 relock via keyA", {31'b0, unlocked}, 0);
    wr(PLO, 32'h1, p);
    chk("R9 after relock", {31'b0, p}, 0);

    // R10 progress held across other writes
    wr(OA, KA, p);
    wr(PHI, 32'h7, p);
    wr('h08, 32'h9, p);
    wr(PLO, 32'h3, p);
    wr(OB, KB, p);
    chk("R10 progress held", {31'b0, unlocked}, 1);

    // R8 wrong key B relocks
    wr(OB, 32'h0, p);
    chk("R8 relock via keyB", {31'b0, unlocked}, 0);
    rd(OA, d); chk("R2 status cleared", d, {KA[31:1], 1'b0});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule